// File: doc/BRIEF.md
# Selectable Periodic Wakeup Timer

This block raises a periodic wakeup event from one of two time bases. The first is a nominal 1 kHz internal tick. The second is a clock derived from an external crystal. Both arrive as single-cycle enable strobes in the system clock domain.

A 3-bit rate code selects the period, and code zero switches the timer off. Each time the selected period elapses, a sticky flag is set. Software clears it with an acknowledge pulse. An interrupt request follows the flag whenever the interrupt enable is high.

The period table is irregular. Rate code 1 gives the shortest period. From code 2 upward each code doubles the period, starting at four times the code-1 period. The external source uses its own, longer set of divide ratios.

The block registers the source select and the rate code internally. Any change of either one restarts the count, so the first period after a change is a full period.

Top module: `wake_timer`

## Requirements
- R1: After a synchronous active-low reset, `flag` and `irq` are 0, the counter is cleared, and the internal rate setting is code 000.
- R2: While rate code `rate_sel` = 3'b000, no tick on either source ever sets `flag`.
- R3: With `src_ext` = 0, rate codes 1 through 7 set `flag` on the 8th, 32nd, 64th, 128th, 256th, 512th and 1024th `tick_int` strobe respectively, counted from the configuration change. `flag` is visible in the cycle after that strobe.
- R4: With `src_ext` = 1, rate codes 1 through 7 set `flag` on the 256th, 1024th, 2048th, 4096th, 8192nd, 16384th and 32768th `tick_ext` strobe respectively.
- R5: Only the strobe of the selected source advances the count. `tick_int` has no effect while `src_ext` = 1, and `tick_ext` has no effect while `src_ext` = 0.
- R6: `flag` stays set until it is acknowledged. At expiry the counter restarts at zero on the same strobe, so the next period is again exactly the full number of strobes.
- R7: A one-cycle `ack` pulse clears `flag`. If `ack` coincides with an expiring strobe, `flag` stays set.
- R8: Any change of `rate_sel` or `src_ext` restarts the count. Strobes counted under the previous setting do not shorten the next period.
- R9: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1. `rate_sel[2]` is the most significant bit of the rate code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_int | input | 1 | Single-cycle strobe from the 1 kHz internal time base |
| tick_ext | input | 1 | Single-cycle strobe from the external crystal-derived clock |
| src_ext | input | 1 | Source select: 0 internal tick, 1 external clock |
| rate_sel | input | 3 | Rate code, bit 2 most significant; 000 disables |
| ack | input | 1 | Acknowledge pulse that clears the flag |
| irq_en | input | 1 | Interrupt enable |
| flag | output | 1 | Sticky period-elapsed flag |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The bench builds the block with its default exponents: 3 for the internal base and 8 for the external base. This gives the full table up to a 32768-strobe divide. Every code on both sources is therefore run to its exact expiry, and the longest period exercises the top bit of the counter.

Strobes arrive back to back, and also with idle gaps between them. This shows that the count depends on strobes rather than on clock cycles.

// File: rtl/wake_timer_pkg.sv
// Package: shared definitions for the periodic wakeup timer.
// Assumes: a rate code of 1 maps to 2**base strobes, and a code k >= 2
// maps to 2**(base+k) strobes.
package wake_timer_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } wk_src_e;

    // Period exponent for a rate code; code 0 is unused (timer off).
    function automatic int unsigned period_log2(input int unsigned code,
                                                input int unsigned base);
        if (code == 0) begin
            return 0;
        end else if (code == 1) begin
            return base;
        end
        return base + code;
    endfunction

endpackage

// File: rtl/wk_rate_map.sv
// Module: wk_rate_map
// Maps the registered rate code and source to a terminal count (period-1).
// Builds one terminal-count table per source from the package rule.
// Assumes: CNT_W can hold 2**(max exponent) - 1.
module wk_rate_map
    import wake_timer_pkg::*;
#(
    parameter int unsigned INT_LOG2 = 3,
    parameter int unsigned EXT_LOG2 = 8,
    parameter int unsigned CNT_W    = 15
) (
    input  logic [2:0]       code,
    input  logic             src,
    output logic [CNT_W-1:0] term,
    output logic             active
);

    localparam int unsigned NCODES = 8;

    logic [CNT_W-1:0] int_term [NCODES];
    logic [CNT_W-1:0] ext_term [NCODES];

    // Table entries, one per rate code, for both sources.
    for (genvar g = 0; g < NCODES; g++) begin : g_tab
        localparam int unsigned IL = period_log2(g, INT_LOG2);
        localparam int unsigned EL = period_log2(g, EXT_LOG2);
        localparam int unsigned IT = (g == 0) ? 0 : ((1 << IL) - 1);
        localparam int unsigned ET = (g == 0) ? 0 : ((1 << EL) - 1);
        assign int_term[g] = CNT_W'(IT);
        assign ext_term[g] = CNT_W'(ET);
    end

    // Select the entry for the current code and source.
    always_comb begin
        term   = (src == SRC_EXT) ? ext_term[code] : int_term[code];
        active = (code != 3'b000);
    end

    // R3 R4: an active entry is one less than a power of two
    always_comb begin
        if (active) begin
            pow2_term_chk: assert ($countones({1'b0, term} + 1'b1) == 1);
        end
    end

endmodule

// File: rtl/wk_prescaler.sv
// Module: wk_prescaler
// Counts strobes of the selected source up to the terminal count and
// gives a one-cycle expiry pulse, wrapping to zero on the same strobe.
// Assumes: cfg_change is high for one cycle when the setting changes.
module wk_prescaler #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             cfg_change,
    input  logic [CNT_W-1:0] term,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic             at_term;

    // Terminal detection and expiry on a counted strobe.
    always_comb begin
        at_term = (cnt == term);
        expire  = tick && active && !cfg_change && at_term;
    end

    // Strobe counter with restart on a change, while off, and on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cfg_change || !active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_term ? '0 : cnt + ONE;
        end
    end

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (cnt == '0));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == '0));

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0) && !expire);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_change) |-> (cnt <= term));

endmodule

// File: rtl/wk_flag.sv
// Module: wk_flag
// Sticky period flag with acknowledge; expiry wins over a same-cycle ack.
// The interrupt request is the flag gated by the enable.
module wk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    // Set on expiry, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= expire || (flag && !ack);
        end
    end

    // Gate the flag onto the request line.
    always_comb begin
        irq = flag && irq_en;
    end

    // R6
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> !flag);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !expire) |=> !flag);

endmodule

// File: rtl/wake_timer.sv
// Module: wake_timer (top)
// Periodic wakeup timer with a choice of two strobe sources and a 3-bit rate.
// Registers the source and rate internally. A change of either one
// restarts the count.
// Assumes: tick_int and tick_ext are one-cycle strobes already in the clk
// domain; rst_n is synchronous, active low.
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int unsigned INT_LOG2 = 3,
    parameter int unsigned EXT_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_int,
    input  logic       tick_ext,
    input  logic       src_ext,
    input  logic [2:0] rate_sel,
    input  logic       ack,
    input  logic       irq_en,
    output logic       flag,
    output logic       irq
);

    localparam int unsigned MAX_LOG = (INT_LOG2 > EXT_LOG2) ? INT_LOG2 : EXT_LOG2;
    localparam int unsigned CNT_W   = MAX_LOG + 7;

    logic [2:0]       sel_q;
    wk_src_e          src_q;
    logic             cfg_change;
    logic             tick_sel;
    logic             active;
    logic             expire;
    logic [CNT_W-1:0] term;

    // Detect a new setting and pick the strobe of the held source.
    always_comb begin
        cfg_change = (rate_sel != sel_q) || (src_ext != src_q);
        tick_sel   = (src_q == SRC_EXT) ? tick_ext : tick_int;
    end

    // Hold the setting the counter is running under.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 3'b000;
            src_q <= SRC_INT;
        end else if (cfg_change) begin
            sel_q <= rate_sel;
            src_q <= wk_src_e'(src_ext);
        end
    end

    wk_rate_map #(
        .INT_LOG2 (INT_LOG2),
        .EXT_LOG2 (EXT_LOG2),
        .CNT_W    (CNT_W)
    ) u_map (
        .code   (sel_q),
        .src    (src_q),
        .term   (term),
        .active (active)
    );

    wk_prescaler #(
        .CNT_W (CNT_W)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_sel),
        .active     (active),
        .cfg_change (cfg_change),
        .term       (term),
        .expire     (expire)
    );

    wk_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .ack    (ack),
        .irq_en (irq_en),
        .flag   (flag),
        .irq    (irq)
    );

    // R8
    cfg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (sel_q == $past(rate_sel)) && (src_q == wk_src_e'($past(src_ext))));

    // R5
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_sel) |-> !expire);

endmodule

// File: tb/wake_timer_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for wake_timer, one task each.
module wake_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_int = 1'b0;
    logic       tick_ext = 1'b0;
    logic       src_ext = 1'b0;
    logic [2:0] rate_sel = 3'b000;
    logic       ack = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag;
    logic       irq;

    int checks = 0;
    int errors = 0;

    wake_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .src_ext  (src_ext),
        .rate_sel (rate_sel),
        .ack      (ack),
        .irq_en   (irq_en),
        .flag     (flag),
        .irq      (irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply a setting at a negedge; one edge absorbs it with no strobe.
    task automatic configure(input bit ext, input logic [2:0] code);
        @(negedge clk);
        src_ext  = ext;
        rate_sel = code;
        @(negedge clk);
    endtask

    // Issue n strobes on one line; pre is the flag just before the last one.
    task automatic run_ticks(input int n, input bit ext, input int gap,
                             input bit ack_last, output bit pre);
        pre = 1'b0;
        for (int k = 1; k <= n; k++) begin
            if (k == n) begin
                pre = flag;
                ack = ack_last;
            end
            if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            if (gap > 0 || k == n) begin
                tick_int = 1'b0;
                tick_ext = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    function automatic int period_of(input bit ext, input int code);
        int base;
        base = ext ? 8 : 3;
        return (code == 1) ? (1 << base) : (1 << (base + code));
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 flag after reset", flag, 0);
        chk("R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after release", flag, 0);
    endtask

    task automatic t_internal();
        bit pre;
        for (int c = 1; c <= 7; c++) begin
            configure(1'b0, 3'(c));
            run_ticks(period_of(1'b0, c), 1'b0, (c == 1) ? 2 : 0, 1'b0, pre);
            chk($sformatf("R3 code %0d before last tick", c), pre, 0);
            chk($sformatf("R3 code %0d after last tick", c), flag, 1);
            pulse_ack();
        end
    endtask

    task automatic t_external();
        bit pre;
        for (int c = 1; c <= 7; c++) begin
            configure(1'b1, 3'(c));
            run_ticks(period_of(1'b1, c), 1'b1, (c == 1) ? 1 : 0, 1'b0, pre);
            chk($sformatf("R4 code %0d before last tick", c), pre, 0);
            chk($sformatf("R4 code %0d after last tick", c), flag, 1);
            pulse_ack();
        end
    endtask

    task automatic t_off();
        bit pre;
        configure(1'b0, 3'b000);
        run_ticks(1100, 1'b0, 0, 1'b0, pre);
        chk("R2 off internal", flag, 0);
        configure(1'b1, 3'b000);
        run_ticks(1100, 1'b1, 0, 1'b0, pre);
        chk("R2 off external", flag, 0);
    endtask

    task automatic t_source_gate();
        bit pre;
        configure(1'b1, 3'b001);
        run_ticks(300, 1'b0, 0, 1'b0, pre);
        chk("R5 internal strobes ignored on external", flag, 0);
        run_ticks(256, 1'b1, 0, 1'b0, pre);
        chk("R5 external period intact before", pre, 0);
        chk("R5 external period intact after", flag, 1);
        pulse_ack();
        configure(1'b0, 3'b001);
        run_ticks(20, 1'b1, 0, 1'b0, pre);
        run_ticks(8, 1'b0, 0, 1'b0, pre);
        chk("R5 external strobes ignored on internal", pre, 0);
        chk("R5 internal period after ignored", flag, 1);
        pulse_ack();
    endtask

    task automatic t_sticky();
        bit pre;
        configure(1'b0, 3'b010);
        run_ticks(32, 1'b0, 0, 1'b0, pre);
        chk("R6 first period", flag, 1);
        run_ticks(10, 1'b0, 0, 1'b0, pre);
        chk("R6 flag sticky without ack", flag, 1);
        pulse_ack();
        run_ticks(22, 1'b0, 0, 1'b0, pre);
        chk("R6 back-to-back period before", pre, 0);
        chk("R6 back-to-back period after", flag, 1);
        pulse_ack();
    endtask

    task automatic t_ack();
        bit pre;
        configure(1'b0, 3'b001);
        run_ticks(8, 1'b0, 0, 1'b0, pre);
        pulse_ack();
        chk("R7 ack clears", flag, 0);
        run_ticks(8, 1'b0, 0, 1'b0, pre);
        run_ticks(8, 1'b0, 0, 1'b1, pre);
        chk("R7 ack with expiry keeps flag", flag, 1);
        pulse_ack();
        chk("R7 later ack clears", flag, 0);
    endtask

    task automatic t_change();
        bit pre;
        configure(1'b0, 3'b001);
        run_ticks(5, 1'b0, 0, 1'b0, pre);
        configure(1'b0, 3'b010);
        run_ticks(32, 1'b0, 0, 1'b0, pre);
        chk("R8 rate change full period before", pre, 0);
        chk("R8 rate change full period after", flag, 1);
        pulse_ack();
        configure(1'b1, 3'b001);
        run_ticks(200, 1'b1, 0, 1'b0, pre);
        configure(1'b0, 3'b001);
        configure(1'b1, 3'b001);
        run_ticks(256, 1'b1, 0, 1'b0, pre);
        chk("R8 source change full period before", pre, 0);
        chk("R8 source change full period after", flag, 1);
        pulse_ack();
    endtask

    task automatic t_irq();
        bit pre;
        configure(1'b0, 3'b001);
        irq_en = 1'b0;
        run_ticks(8, 1'b0, 0, 1'b0, pre);
        chk("R9 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R9 irq enabled", irq, 1);
        pulse_ack();
        chk("R9 irq after ack", irq, 0);
        irq_en = 1'b0;
        // rate 3'b100 (bit 2 set) must map to 128 internal strobes
        configure(1'b0, 3'b100);
        run_ticks(128, 1'b0, 0, 1'b0, pre);
        chk("R9 msb code 100 before", pre, 0);
        chk("R9 msb code 100 after", flag, 1);
        pulse_ack();
    endtask

    initial begin
        t_reset();
        t_internal();
        t_external();
        t_off();
        t_source_gate();
        t_sticky();
        t_ack();
        t_change();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule